// File: doc/BRIEF.md
# Mersenne-Prime Sixteen-Cell Shift Register

This block holds sixteen 31-bit cells whose feedback arithmetic works modulo the prime 2^31−1. A single-cycle parallel load fills the cells from a 128-bit key, a 128-bit IV and a fixed table of sixteen 15-bit constants. Each step moves every cell down one place and writes a freshly computed feedback value into the top cell. The feedback is a weighted sum of five cells. Each weight is a power of two, so each product is a bit rotation, and the terms are combined by end-around-carry additions arranged as a balanced tree.

There are two step modes. In initialization mode a 31-bit word from outside is added into the feedback. In work mode that word is ignored. All sixteen cells are driven out in parallel, so that a surrounding sequencer can pick the bit fields it needs. Control stays plain. `step_i` acts as a valid strobe that the block always accepts at once, so there is no ready signal and no back-pressure. The external word only has to be stable during the cycle in which `step_i` is high.

Top module: `mlfsr_core`

## Requirements
- R1: While `rst_n` is low, every cell reads 0x7FFFFFFF. Cell i appears on `cells_o[31*i +: 31]`.
- R2: A cycle with `load_i` high sets cell i, at the next edge, to {key byte i, constant c_i, IV byte i}. The key byte takes cell bits [30:23], the constant bits [22:8] and the IV byte bits [7:0]. Byte i is taken from bits [127-8i -: 8], so byte 0 is the most significant. The constants c0..c15 are 44D7, 26BC, 626B, 135E, 5789, 35E2, 7135, 09AF, 4D78, 2F13, 6BC4, 1AF1, 5E26, 3C4D, 789A, 47AC (hex).
- R3: When `load_i` and `step_i` are both high in the same cycle, the load wins and no step happens.
- R4: A step (with `load_i` low) makes cell i take the old value of cell i+1 for i = 0..14 at the next clock edge.
- R5: In a work-mode step (`init_mode_i` low), cell 15 becomes (2^15·c15 + 2^17·c13 + 2^21·c10 + 2^20·c4 + 257·c0) mod 2^31−1, using the old cell values. `fb_in_i` has no effect.
- R6: In an initialization-mode step (`init_mode_i` high), cell 15 becomes (the R5 sum + `fb_in_i`) mod 2^31−1.
- R7: A feedback result congruent to 0 is stored as 0x7FFFFFFF, so no cell ever holds 0.
- R8: When `step_i` and `load_i` are both low, all cells hold their values whatever `init_mode_i` and `fb_in_i` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Parallel load from key, IV and constants |
| key_i | input | 128 | Key, byte 0 in bits [127:120] |
| iv_i | input | 128 | IV, byte 0 in bits [127:120] |
| step_i | input | 1 | Advance the register by one cell |
| init_mode_i | input | 1 | 1: add `fb_in_i` into the feedback; 0: work mode |
| fb_in_i | input | 31 | External word added in initialization mode |
| cells_o | output | 496 | All cells, cell i at [31*i +: 31] |

## Verification
The assertions assume that the control inputs are never X after reset. They also assume that a load precedes any step whose cell values matter, although the reset value of 0x7FFFFFFF is itself a legal nonzero state, so the nonzero property holds in every case. The stimulus drives every input at the falling edge, away from the sampling edge. It mixes loads, steps in both modes, idle cycles and collisions between load and step, drawn from a seeded generator. On top of that come directed cases: all-zero and all-ones key and IV, an external word of 0x7FFFFFFF, and an external word chosen so that the initialization sum is exactly 0 modulo the prime.

// File: rtl/mlfsr_pkg.sv
package mlfsr_pkg;
  localparam int N_CELLS  = 16;
  localparam int CELL_W   = 31;
  localparam int BYTE_W   = 8;
  localparam int CONST_W  = CELL_W - 2 * BYTE_W;
  localparam int KEY_W    = N_CELLS * BYTE_W;
  localparam int N_TAPS   = 6;

  typedef logic [CELL_W-1:0] cell_t;

  localparam cell_t CELL_MAX = {CELL_W{1'b1}};

  // Weighted feedback taps: cell index and rotation (power of two).
  localparam int TAP_CELL [N_TAPS] = '{0, 0, 4, 10, 13, 15};
  localparam int TAP_ROT  [N_TAPS] = '{0, 8, 20, 21, 17, 15};

  function automatic cell_t rotl(input cell_t x, input int k);
    return (x << k) | (x >> (CELL_W - k));
  endfunction

  function automatic logic [CONST_W-1:0] seed_const(input int i);
    case (i)
      0:  return 15'h44D7;
      1:  return 15'h26BC;
      2:  return 15'h626B;
      3:  return 15'h135E;
      4:  return 15'h5789;
      5:  return 15'h35E2;
      6:  return 15'h7135;
      7:  return 15'h09AF;
      8:  return 15'h4D78;
      9:  return 15'h2F13;
      10: return 15'h6BC4;
      11: return 15'h1AF1;
      12: return 15'h5E26;
      13: return 15'h3C4D;
      14: return 15'h789A;
      default: return 15'h47AC;
    endcase
  endfunction
endpackage

// File: rtl/mlfsr_madd.sv
// Addition modulo 2^W-1 by end-around carry; inputs in [0, 2^W-1].
module mlfsr_madd #(
  parameter int W = 31
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  logic [W:0] sum;
  assign sum = {1'b0, a_i} + {1'b0, b_i};
  assign y_o = sum[W-1:0] + {{(W-1){1'b0}}, sum[W]};
endmodule

// File: rtl/mlfsr_seed.sv
// Builds the load image: key byte, fixed constant, IV byte per cell.
module mlfsr_seed
  import mlfsr_pkg::*;
(
  input  logic [KEY_W-1:0] key_i,
  input  logic [KEY_W-1:0] iv_i,
  output cell_t            seed_o [N_CELLS]
);
  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    localparam int HI = KEY_W - 1 - BYTE_W * i;
    assign seed_o[i] = {key_i[HI -: BYTE_W], seed_const(i), iv_i[HI -: BYTE_W]};
  end
endmodule

// File: rtl/mlfsr_feedback.sv
// Balanced tree of modular adders over the rotated taps plus the
// optional external word; a zero result is replaced by 2^31-1.
module mlfsr_feedback
  import mlfsr_pkg::*;
(
  input  cell_t cells_i [N_CELLS],
  input  cell_t fb_in_i,
  input  logic  init_mode_i,
  output cell_t fb_o
);
  localparam int LEAVES = 8;
  localparam int NODES  = 2 * LEAVES - 1;

  cell_t node [NODES];

  for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
    assign node[LEAVES-1+t] = rotl(cells_i[TAP_CELL[t]], TAP_ROT[t]);
  end
  assign node[LEAVES-1+N_TAPS]   = init_mode_i ? fb_in_i : '0;
  assign node[LEAVES-1+N_TAPS+1] = '0;

  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_add
    mlfsr_madd #(.W(CELL_W)) u_add (
      .a_i (node[2*n+1]),
      .b_i (node[2*n+2]),
      .y_o (node[n])
    );
  end

  assign fb_o = (node[0] == '0) ? CELL_MAX : node[0];
endmodule

// File: rtl/mlfsr_core.sv
module mlfsr_core
  import mlfsr_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_i,
  input  logic [KEY_W-1:0]           key_i,
  input  logic [KEY_W-1:0]           iv_i,
  input  logic                       step_i,
  input  logic                       init_mode_i,
  input  logic [CELL_W-1:0]          fb_in_i,
  output logic [N_CELLS*CELL_W-1:0]  cells_o
);
  cell_t cells_q [N_CELLS];
  cell_t seed    [N_CELLS];
  cell_t fb;

  mlfsr_seed u_seed (
    .key_i  (key_i),
    .iv_i   (iv_i),
    .seed_o (seed)
  );

  mlfsr_feedback u_fb (
    .cells_i     (cells_q),
    .fb_in_i     (fb_in_i),
    .init_mode_i (init_mode_i),
    .fb_o        (fb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CELLS; i++) cells_q[i] <= CELL_MAX;
    end else if (load_i) begin
      for (int i = 0; i < N_CELLS; i++) cells_q[i] <= seed[i];
    end else if (step_i) begin
      for (int i = 0; i < N_CELLS - 1; i++) cells_q[i] <= cells_q[i+1];
      cells_q[N_CELLS-1] <= fb;
    end
  end

  for (genvar i = 0; i < N_CELLS; i++) begin : g_out
    assign cells_o[CELL_W*i +: CELL_W] = cells_q[i];
  end
endmodule

// File: rtl/mlfsr_checker.sv
module mlfsr_checker
  import mlfsr_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      load_i,
  input logic [KEY_W-1:0]          key_i,
  input logic [KEY_W-1:0]          iv_i,
  input logic                      step_i,
  input logic [N_CELLS*CELL_W-1:0] cells_o
);
  localparam int TOP = (N_CELLS - 1) * CELL_W;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_nz
    assert_cell_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cells_o[CELL_W*i +: CELL_W] != '0);
  end

  for (genvar i = 0; i < N_CELLS - 1; i++) begin : g_sh
    assert_shift_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=>
        cells_o[CELL_W*i +: CELL_W] == $past(cells_o[CELL_W*(i+1) +: CELL_W]));
  end

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(cells_o));

  assert_load_cell0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cells_o[CELL_W-1:0] ==
      {$past(key_i[KEY_W-1 -: BYTE_W]), 15'h44D7, $past(iv_i[KEY_W-1 -: BYTE_W])});

  assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && step_i) |=> cells_o[TOP +: CELL_W] ==
      {$past(key_i[BYTE_W-1:0]), 15'h47AC, $past(iv_i[BYTE_W-1:0])});
endmodule

bind mlfsr_core mlfsr_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .load_i  (load_i),
  .key_i   (key_i),
  .iv_i    (iv_i),
  .step_i  (step_i),
  .cells_o (cells_o)
);

// File: tb/mlfsr_core_bench.sv
`timescale 1ns/1ps
module mlfsr_core_bench;
  localparam longint unsigned P = 64'h7FFF_FFFF;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n, load_i, step_i, init_mode_i;
  logic [127:0] key_i, iv_i;
  logic [30:0]  fb_in_i;
  logic [495:0] cells_o;

  mlfsr_core u_mlfsr_core (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .key_i(key_i), .iv_i(iv_i),
    .step_i(step_i), .init_mode_i(init_mode_i), .fb_in_i(fb_in_i),
    .cells_o(cells_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [30:0] mdl [16];

  function automatic logic [14:0] cst(input int i);
    logic [14:0] t [16] = '{15'h44D7, 15'h26BC, 15'h626B, 15'h135E, 15'h5789,
      15'h35E2, 15'h7135, 15'h09AF, 15'h4D78, 15'h2F13, 15'h6BC4, 15'h1AF1,
      15'h5E26, 15'h3C4D, 15'h789A, 15'h47AC};
    return t[i];
  endfunction

  // Integer model of the feedback, result in [1, P].
  function automatic logic [30:0] fb_model(input bit im, input logic [30:0] u);
    longint unsigned acc, r;
    acc = 64'(mdl[0]) + (64'(mdl[0]) << 8) + (64'(mdl[4]) << 20)
        + (64'(mdl[10]) << 21) + (64'(mdl[13]) << 17) + (64'(mdl[15]) << 15);
    if (im) acc += 64'(u);
    r = acc % P;
    return (r == 0) ? 31'(P) : 31'(r);
  endfunction

  task automatic compare(input string tag);
    bit bad = 0;
    n_chk++;
    for (int i = 0; i < 16; i++) begin
      if (!bad && cells_o[31*i +: 31] !== mdl[i]) begin
        bad = 1;
        $display("FAIL %s: cell %0d actual %h expected %h", tag, i,
                 cells_o[31*i +: 31], mdl[i]);
      end
    end
    if (bad) n_fail++;
  endtask

  task automatic op(input bit ld, input bit st, input bit im,
                    input logic [127:0] k, input logic [127:0] v,
                    input logic [30:0] u, input string tag);
    logic [30:0] nx [16];
    @(negedge clk);
    load_i = ld; step_i = st; init_mode_i = im; key_i = k; iv_i = v; fb_in_i = u;
    nx = mdl;
    if (ld) begin
      for (int i = 0; i < 16; i++) nx[i] = {k[127-8*i -: 8], cst(i), v[127-8*i -: 8]};
    end else if (st) begin
      for (int i = 0; i < 15; i++) nx[i] = mdl[i+1];
      nx[15] = fb_model(im, u);
    end
    @(posedge clk); #1;
    mdl = nx;
    compare(tag);
  endtask

  function automatic logic [127:0] r128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [30:0] w, u;
    void'($urandom(32'd20240611));
    rst_n = 0; load_i = 0; step_i = 0; init_mode_i = 0;
    key_i = '0; iv_i = '0; fb_in_i = '0;
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < 16; i++) mdl[i] = 31'h7FFFFFFF;
    compare("R1");
    @(negedge clk); rst_n = 1;

    op(1, 0, 0, r128(), r128(), '0, "R2");
    op(1, 0, 0, '0, '0, '0, "R2");
    op(1, 0, 0, '1, '1, '0, "R2");
    op(1, 0, 0, 128'h00112233445566778899AABBCCDDEEFF,
       128'hFFEEDDCCBBAA99887766554433221100, '0, "R2");
    for (int i = 0; i < 4; i++) op(0, 0, $urandom, r128(), r128(), 31'($urandom), "R8");
    for (int i = 0; i < 32; i++) op(0, 1, 1, r128(), r128(), 31'($urandom), "R6");
    op(0, 1, 1, '0, '0, 31'h7FFFFFFF, "R6");
    for (int i = 0; i < 20; i++) op(0, 1, 0, r128(), r128(), 31'($urandom), "R5");
    op(1, 1, 1, r128(), r128(), 31'($urandom), "R3");
    op(1, 1, 0, r128(), r128(), 31'($urandom), "R3");
    for (int i = 0; i < 8; i++) op(0, 1, 0, '0, '0, '0, "R4");

    // Initialization sum exactly 0 mod P.
    for (int j = 0; j < 4; j++) begin
      w = fb_model(0, '0);
      u = (w == 31'h7FFFFFFF) ? 31'h0 : 31'(P - 64'(w));
      op(0, 1, 1, '0, '0, u, "R7");
      if (mdl[15] != 31'h7FFFFFFF) begin
        n_chk++; n_fail++;
        $display("FAIL R7: model actual %h expected 7fffffff", mdl[15]);
      end
    end

    for (int i = 0; i < 3000; i++) begin
      int c = $urandom_range(0, 9);
      op(c == 0, c >= 3 || c == 1, $urandom, r128(), r128(), 31'($urandom),
         (c == 0) ? "R2" : (c == 2) ? "R8" : "R5");
    end

    @(negedge clk); load_i = 0; step_i = 0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule